// File: doc/BRIEF.md
# AES-128 Round Key Store with Shared S-box Expansion

This block turns a 128-bit cipher key into the eleven round keys of AES-128 in one burst after a load strobe and keeps them in a small register file. The round controller of the cipher then asks for any round by index. The direction input decides the order of the keys. In encryption, index r gives round key r. In decryption, index r gives round key 10 minus r. The same stored set serves both directions, so a change of direction needs no new expansion.

The block has no substitution table of its own. The SubWord step of the expansion borrows the byte-substitution lookup port of the round datapath. While the expansion runs, the block takes that port and raises a hold flag that keeps the datapath idle. When the expansion is done, the port goes back to the datapath's own addresses.

The expansion always takes a fixed ten cycles. The key-ready flag drops when a key is loaded and rises when all eleven keys are written. The controller must not start a new data block while that flag is low.

Top module: `aes_key_store`

## Requirements
- R1: After synchronous reset, `key_ready` and `dp_hold` are 0 and `round_key` is all zeros.
- R2: On the clock edge that samples `key_load` high, `key_ready` goes to 0 and `dp_hold` goes to 1, both visible right after that edge.
- R3: The expansion takes exactly ten clock edges after the load edge. `key_ready` rises to 1 and `dp_hold` falls to 0 on the tenth edge, and not earlier.
- R4: While `dp_hold` is 1, `sbox_addr` carries the last 32-bit word of the previous round key, rotated left by one byte. In the first expansion cycle this is `{key_in[23:0], key_in[31:24]}`. `dp_sbox_addr` has no effect on `sbox_addr` during that time.
- R5: While `dp_hold` is 0, `sbox_addr` equals `dp_sbox_addr`.
- R6: With `enc_sel` = 1, index r (0..10) returns round key r of the standard AES-128 expansion. Round constants are 0x01, 0x02, 0x04, 0x08, 0x10, 0x20, 0x40, 0x80, 0x1B, 0x36, XORed into the top byte. The result appears one clock edge after the index is sampled. For key 2b7e151628aed2a6abf7158809cf4f3c, round 1 is a0fafe1788542cb123a339392a6c7605 and round 10 is d014f9a8c9ee2589e13f0cc8b6630ca6.
- R7: With `enc_sel` = 0, index r returns round key 10 minus r, with the same one-edge latency.
- R8: An index above 10 is treated as 10. In encryption it returns round key 10, and in decryption it returns round key 0.
- R9: A `key_load` during a running expansion restarts it from the new key. The R3 timing then counts from the new load edge, and the stored keys are those of the new key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_in | input | 128 | Cipher key, sampled with key_load |
| key_load | input | 1 | Starts a key expansion |
| enc_sel | input | 1 | 1 = encryption order, 0 = decryption order |
| round_idx | input | 4 | Round number requested by the controller |
| round_key | output | 128 | Registered round key |
| key_ready | output | 1 | All round keys are stored |
| dp_hold | output | 1 | Datapath must stay idle; the S-box port is in use by the expansion |
| dp_sbox_addr | input | 32 | Four S-box input bytes from the round datapath |
| sbox_addr | output | 32 | Four bytes presented to the shared S-box |
| sbox_data | input | 32 | Substituted bytes returned by the shared S-box |

## Verification
The expansion is tried with three cipher keys. The standard example key pins the round-constant order and the byte rotation against published values. The 000102..0f key, checked for every index in both directions, separates a forward readout from a reversed one. A third key loaded in the middle of an expansion shows whether the restart discards the partial work. Index values beyond 10 and a datapath address that changes while the port is held show whether clamping and port arbitration are right, apart from the key arithmetic.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;

  // multiply by x in GF(2^8) with the AES polynomial
  function automatic logic [7:0] gf_x(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  // round constant for round rnd (1-based): x^(rnd-1)
  function automatic logic [7:0] rcon_of(input logic [3:0] rnd);
    logic [7:0] r;
    r = 8'h01;
    for (int k = 1; k < 16; k++)
      if (k < int'(rnd)) r = gf_x(r);
    return r;
  endfunction

endpackage

// File: rtl/aes_ks_step.sv
module aes_ks_step #(
  parameter int WORD = 32
) (
  input  logic [4*WORD-1:0] prev_key,
  input  logic [WORD-1:0]   sub_word,
  input  logic [7:0]        rc,
  output logic [WORD-1:0]   rot_word,
  output logic [4*WORD-1:0] next_key
);
  localparam int NW = 4;

  logic [WORD-1:0] last_w;
  logic [WORD-1:0] mix_w;
  logic [WORD-1:0] chain [NW];

  assign last_w   = prev_key[WORD-1:0];
  assign rot_word = {last_w[WORD-9:0], last_w[WORD-1:WORD-8]};
  assign mix_w    = sub_word ^ {rc, {(WORD-8){1'b0}}};

  // word j of the new key: old word j xor the new word j-1 (mix word for j = 0)
  for (genvar j = 0; j < NW; j++) begin : g_word
    if (j == 0) begin : g_first
      assign chain[j] = prev_key[(NW-j)*WORD-1 -: WORD] ^ mix_w;
    end else begin : g_rest
      assign chain[j] = prev_key[(NW-j)*WORD-1 -: WORD] ^ chain[j-1];
    end
    assign next_key[(NW-j)*WORD-1 -: WORD] = chain[j];
  end
endmodule

// File: rtl/aes_ks_ctrl.sv
module aes_ks_ctrl #(
  parameter int NROUNDS = 10,
  parameter int CW      = $clog2(NROUNDS + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          key_load,
  output logic          busy,
  output logic          ready,
  output logic [CW-1:0] cnt,
  output logic          wr_en,
  output logic [CW-1:0] wr_idx
);
  localparam logic [CW-1:0] LAST = CW'(NROUNDS);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      ready <= 1'b0;
      cnt   <= '0;
    end else if (key_load) begin
      busy  <= 1'b1;
      ready <= 1'b0;
      cnt   <= CW'(1);
    end else if (busy) begin
      cnt <= cnt + CW'(1);
      if (cnt == LAST) begin
        busy  <= 1'b0;
        ready <= 1'b1;
      end
    end
  end

  assign wr_en  = key_load | busy;
  assign wr_idx = key_load ? '0 : cnt;

  // independent watch of how long the expansion has been running
  logic [CW-1:0] run_len;
  always_ff @(posedge clk) begin
    if (rst || key_load) run_len <= '0;
    else if (busy)       run_len <= run_len + CW'(1);
  end

  assert_load_drops_ready_R2: assert property (@(posedge clk) disable iff (rst)
    key_load |=> !ready);
  assert_busy_excl_ready_R3: assert property (@(posedge clk) disable iff (rst)
    !(busy && ready));
  assert_expand_bounded_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> run_len < CW'(NROUNDS));
  assert_done_sets_ready_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ready);
endmodule

// File: rtl/aes_ks_regfile.sv
module aes_ks_regfile #(
  parameter int DEPTH = 11,
  parameter int DW    = 128,
  parameter int AW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end

  assert_waddr_range_R6: assert property (@(posedge clk) disable iff (rst)
    we |-> int'(waddr) < DEPTH);
  assert_raddr_range_R8: assert property (@(posedge clk) disable iff (rst)
    int'(raddr) < DEPTH);
endmodule

// File: rtl/aes_key_store.sv
module aes_key_store #(
  parameter int NROUNDS = 10,
  parameter int WORD    = 32,
  parameter int KEYW    = 4 * WORD,
  parameter int IDXW    = $clog2(NROUNDS + 2)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [KEYW-1:0] key_in,
  input  logic            key_load,
  input  logic            enc_sel,
  input  logic [IDXW-1:0] round_idx,
  output logic [KEYW-1:0] round_key,
  output logic            key_ready,
  output logic            dp_hold,
  input  logic [WORD-1:0] dp_sbox_addr,
  output logic [WORD-1:0] sbox_addr,
  input  logic [WORD-1:0] sbox_data
);
  import aes_ks_pkg::*;

  localparam int DEPTH = NROUNDS + 1;
  localparam logic [IDXW-1:0] LAST = IDXW'(NROUNDS);

  logic            busy;
  logic [IDXW-1:0] cnt;
  logic            wr_en;
  logic [IDXW-1:0] wr_idx;
  logic [KEYW-1:0] work_q;
  logic [KEYW-1:0] next_key;
  logic [WORD-1:0] rot_word;
  logic [KEYW-1:0] wr_data;
  logic [IDXW-1:0] idx_c;
  logic [IDXW-1:0] rd_idx;

  aes_ks_ctrl #(.NROUNDS(NROUNDS), .CW(IDXW)) u_ctrl (
    .clk(clk), .rst(rst), .key_load(key_load),
    .busy(busy), .ready(key_ready), .cnt(cnt),
    .wr_en(wr_en), .wr_idx(wr_idx)
  );

  aes_ks_step #(.WORD(WORD)) u_step (
    .prev_key(work_q), .sub_word(sbox_data), .rc(rcon_of(cnt)),
    .rot_word(rot_word), .next_key(next_key)
  );

  // previous round key, feeding the next expansion step
  always_ff @(posedge clk) begin
    if (rst)           work_q <= '0;
    else if (key_load) work_q <= key_in;
    else if (busy)     work_q <= next_key;
  end

  // shared S-box port: expansion has priority, datapath is held meanwhile
  assign dp_hold   = busy;
  assign sbox_addr = busy ? rot_word : dp_sbox_addr;
  assign wr_data   = key_load ? key_in : next_key;

  // order of readout follows direction; out-of-range index clamps to last
  assign idx_c  = (round_idx > LAST) ? LAST : round_idx;
  assign rd_idx = enc_sel ? idx_c : LAST - idx_c;

  aes_ks_regfile #(.DEPTH(DEPTH), .DW(KEYW), .AW(IDXW)) u_rf (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(wr_idx), .wdata(wr_data),
    .raddr(rd_idx), .rdata(round_key)
  );

  assert_load_holds_dp_R2: assert property (@(posedge clk) disable iff (rst)
    key_load |=> dp_hold);
  assert_hold_not_ready_R5: assert property (@(posedge clk) disable iff (rst)
    dp_hold |-> !key_ready);
  assert_ready_stays_R9: assert property (@(posedge clk) disable iff (rst)
    (key_ready && !key_load) |=> key_ready);
endmodule

// File: tb/aes_key_store_test.sv
module aes_key_store_test;
  logic         clk = 1'b0;
  logic         rst;
  logic [127:0] key_in;
  logic         key_load;
  logic         enc_sel;
  logic [3:0]   round_idx;
  logic [127:0] round_key;
  logic         key_ready;
  logic         dp_hold;
  logic [31:0]  dp_sbox_addr;
  logic [31:0]  sbox_addr;
  logic [31:0]  sbox_data;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  aes_key_store uut (
    .clk(clk), .rst(rst), .key_in(key_in), .key_load(key_load),
    .enc_sel(enc_sel), .round_idx(round_idx), .round_key(round_key),
    .key_ready(key_ready), .dp_hold(dp_hold), .dp_sbox_addr(dp_sbox_addr),
    .sbox_addr(sbox_addr), .sbox_data(sbox_data)
  );

  // ---------- S-box computed from the field inverse and affine map ----------
  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, aa, bb;
    p = 0; aa = a; bb = b;
    for (int i = 0; i < 8; i++) begin
      if (bb[0]) p = p ^ aa;
      aa = {aa[6:0], 1'b0} ^ (aa[7] ? 8'h1b : 8'h00);
      bb = bb >> 1;
    end
    return p;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] sb(input logic [7:0] x);
    logic [7:0] inv;
    inv = 0;
    for (int y = 1; y < 256; y++)
      if (gmul(x, 8'(y)) == 8'h01) inv = 8'(y);
    return inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3) ^ rotl8(inv, 4) ^ 8'h63;
  endfunction

  assign sbox_data = {sb(sbox_addr[31:24]), sb(sbox_addr[23:16]),
                      sb(sbox_addr[15:8]),  sb(sbox_addr[7:0])};

  // ---------- reference expansion ----------
  logic [127:0] model [0:10];

  task automatic build_model(input logic [127:0] k);
    logic [31:0] w [0:43];
    logic [31:0] t;
    logic [7:0]  rc;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {sb(t[31:24]), sb(t[23:16]), sb(t[15:8]), sb(t[7:0])} ^ {rc, 24'h0};
        rc = {rc[6:0], 1'b0} ^ (rc[7] ? 8'h1b : 8'h00);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) model[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  // ---------- checking helpers ----------
  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_key(input logic e, input logic [3:0] idx);
    @(negedge clk);
    enc_sel = e; round_idx = idx;
    @(negedge clk);
  endtask

  // load, then check R2/R4 after the load edge and R3 over the ten edges
  task automatic load_and_wait(input logic [127:0] k, input string req);
    @(negedge clk);
    key_in = k; key_load = 1'b1;
    @(negedge clk);
    key_load = 1'b0;
    chk({req, " R2 ready low"}, 128'(key_ready), 128'(0));
    chk({req, " R2 hold high"}, 128'(dp_hold), 128'(1));
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      if (i == 9 || i == 10) begin
        chk({req, " R3 ready timing"}, 128'(key_ready), 128'(i == 10));
        chk({req, " R3 hold timing"}, 128'(dp_hold), 128'(i != 10));
      end
    end
  endtask

  // {enc, idx, expected key} for the standard example key
  localparam logic [132:0] VEC [0:8] = '{
    {1'b1, 4'd0,  128'h2b7e151628aed2a6abf7158809cf4f3c},
    {1'b1, 4'd1,  128'ha0fafe1788542cb123a339392a6c7605},
    {1'b1, 4'd2,  128'hf2c295f27a96b9435935807a7359f67f},
    {1'b1, 4'd10, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6},
    {1'b0, 4'd0,  128'hd014f9a8c9ee2589e13f0cc8b6630ca6},
    {1'b0, 4'd9,  128'ha0fafe1788542cb123a339392a6c7605},
    {1'b0, 4'd10, 128'h2b7e151628aed2a6abf7158809cf4f3c},
    {1'b1, 4'd15, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6},
    {1'b0, 4'd13, 128'h2b7e151628aed2a6abf7158809cf4f3c}
  };

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; key_in = '0; key_load = 1'b0; enc_sel = 1'b1;
    round_idx = '0; dp_sbox_addr = 32'h12345678;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 ready", 128'(key_ready), 128'(0));
    chk("R1 hold", 128'(dp_hold), 128'(0));
    chk("R1 key", round_key, 128'(0));
    rst = 1'b0;
    @(negedge clk);

    // R4: first expansion cycle uses rotated last word, datapath address ignored
    key_in = 128'h2b7e151628aed2a6abf7158809cf4f3c; key_load = 1'b1;
    @(negedge clk);
    key_load = 1'b0;
    chk("R4 rotword", 128'(sbox_addr), 128'(32'hcf4f3c09));
    dp_sbox_addr = 32'hdeadbeef;
    #1;
    chk("R4 dp ignored", 128'(sbox_addr), 128'(32'hcf4f3c09));
    repeat (12) @(negedge clk);
    // R5: idle port follows datapath
    chk("R5 passthru", 128'(sbox_addr), 128'(32'hdeadbeef));
    dp_sbox_addr = 32'h00ff10a5;
    #1;
    chk("R5 passthru2", 128'(sbox_addr), 128'(32'h00ff10a5));

    // R3/R2 timing, then the vector table (R6, R7, R8)
    load_and_wait(128'h2b7e151628aed2a6abf7158809cf4f3c, "fips");
    foreach (VEC[i]) begin
      read_key(VEC[i][132], VEC[i][131:128]);
      chk(VEC[i][132] ? (VEC[i][131:128] > 10 ? "R8 enc clamp" : "R6 enc")
                      : (VEC[i][131:128] > 10 ? "R8 dec clamp" : "R7 dec"),
          round_key, VEC[i][127:0]);
    end

    // R6/R7 full sweep on a second key against the reference expansion
    build_model(128'h000102030405060708090a0b0c0d0e0f);
    load_and_wait(128'h000102030405060708090a0b0c0d0e0f, "seq");
    for (int r = 0; r <= 10; r++) begin
      read_key(1'b1, 4'(r));
      chk("R6 sweep", round_key, model[r]);
      read_key(1'b0, 4'(r));
      chk("R7 sweep", round_key, model[10-r]);
    end

    // R9: reload during expansion restarts it
    @(negedge clk);
    key_in = 128'hffeeddccbbaa99887766554433221100; key_load = 1'b1;
    @(negedge clk);
    key_load = 1'b0;
    repeat (4) @(negedge clk);
    build_model(128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0);
    load_and_wait(128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0, "R9 restart");
    for (int r = 0; r <= 10; r += 5) begin
      read_key(1'b1, 4'(r));
      chk("R9 keys", round_key, model[r]);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule